// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises 8-bit or 9-bit data words onto a single output line. Each word is framed by a low start bit and a high stop bit and goes out least significant bit first. One bit is sent per pulse of an external baud tick. A one-word holding buffer sits in front of the shift register, so software can queue the next word while the current frame is still going out. The words then leave back to back, with no gap between the stop bit of one frame and the start bit of the next.

Software drives the block with register-style strobes: a data write (`wr_data` with `wdata`) and a status read (`rd_status`). Level controls select the word length, supply the ninth data bit, enable the transmitter and enable each interrupt source. Two flags are visible: buffer-empty and transfer-complete. Both are cleared only by a status read followed by a data write. Turning the transmitter on first sends one idle frame, which is a frame-length stretch of high bits.

The control path is a four-state machine:
- OFF: line high. It goes to IDLE_FRAME when the enable is high.
- IDLE_FRAME: shifts out all ones. It goes to SEND when a word is pending at the frame end, otherwise to READY.
- READY: line high. A data write moves it to SEND.
- SEND: shifts out a word. At the frame end it stays in SEND if another word is pending, otherwise it goes to READY.

Any state falls back to OFF when the enable drops.

Top module: `sertx_top`

## Requirements
- R1: After reset, `buf_empty`=1, `xfer_done`=1, `txd`=1, and no frame is in progress.
- R2: While `tx_en`=0, `txd` is 1 from the next cycle on, and data writes are ignored: they start no frame and do not change either flag.
- R3: When `tx_en` rises, the block first sends an idle frame of 10 (8-bit mode) or 11 (9-bit mode) bit times, all high. A word written during that frame starts right after it.
- R4: A frame is a start bit of 0, then the data bits least significant first, then a stop bit of 1. Each bit is held until the next `baud_tick`, and the start bit appears the cycle after the load.
- R5: With `word9`=1 the frame carries nine data bits. Bit 8, sent just before the stop bit, is the level of `bit9_val` when the word is loaded.
- R6: A data write while no frame is in progress (READY) loads the shift register directly, and `buf_empty` is 1 in the next cycle.
- R7: A data write during a frame goes into the holding buffer. That word is sent from the tick that ends the current frame, and `buf_empty` is set at that same edge.
- R8: `xfer_done` is set at the edge of the tick that ends a frame with no word pending. It is not set while a word is pending.
- R9: A data write clears `buf_empty` and `xfer_done` only if a status read came before it. A write without a prior read leaves both flags unchanged, apart from the set of R6.
- R10: Any flag-setting event disarms the pending status read, so a later write no longer clears the flags.
- R11: `irq` = (`buf_empty` AND `be_ie`) OR (`xfer_done` AND `tc_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse, one per bit time |
| tx_en | input | 1 | Transmitter enable |
| word9 | input | 1 | 1 selects 9-bit words |
| bit9_val | input | 1 | Ninth data bit used in 9-bit mode |
| be_ie | input | 1 | Buffer-empty interrupt enable |
| tc_ie | input | 1 | Transfer-complete interrupt enable |
| rd_status | input | 1 | Status-read strobe (arms the flag clear) |
| wr_data | input | 1 | Data-write strobe |
| wdata | input | DW | Data word to send |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding buffer empty flag |
| xfer_done | output | 1 | Transfer complete flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume `baud_tick` is a single-cycle pulse and that `word9` and `bit9_val` stay stable while a frame is being shifted, since they are sampled at each load. The bench holds these levels constant across every frame, changing them only in READY. It spaces ticks two cycles apart and issues status reads and data writes only in cycles where no tick is present. This keeps every flag-set event and clear event in a distinct cycle, so each expected flag value is unambiguous.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        S_OFF        = 2'd0,
        S_IDLE_FRAME = 2'd1,
        S_READY      = 2'd2,
        S_SEND       = 2'd3
    } tx_state_e;
endpackage

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tx_en,
    input  logic          word9,
    input  logic          bit9_val,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          txd,
    output logic          ld_direct,
    output logic          ld_hold,
    output logic          done_empty,
    output logic          wr_ok
);
    localparam int FW = DW + 3;
    localparam int CW = $clog2(FW + 1);

    tx_state_e     state, state_nx;
    logic [FW-1:0] sh;
    logic [CW-1:0] cnt;
    logic [DW-1:0] hold;
    logic          hold_full;
    logic          busy, last, pend, wr_busy;
    logic [DW-1:0] next_word;
    logic [CW-1:0] flen;

    function automatic logic [FW-1:0] frame_of(input logic [DW-1:0] d,
                                               input logic m9, input logic b8);
        return m9 ? {1'b1, b8, d, 1'b0} : {2'b11, d, 1'b0};
    endfunction

    always_comb begin
        busy      = (state == S_IDLE_FRAME) || (state == S_SEND);
        last      = busy && tick && (cnt == CW'(1));
        wr_ok     = wr && tx_en && (state != S_OFF);
        wr_busy   = wr_ok && busy;
        ld_direct = wr_ok && (state == S_READY);
        pend      = hold_full || wr_busy;
        ld_hold   = last && pend;
        done_empty = last && !pend;
        next_word = wr_busy ? wdata : hold;
        flen      = word9 ? CW'(FW) : CW'(FW - 1);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:        if (tx_en) state_nx = S_IDLE_FRAME;
            S_IDLE_FRAME,
            S_SEND: begin
                if (!tx_en)    state_nx = S_OFF;
                else if (last) state_nx = pend ? S_SEND : S_READY;
            end
            S_READY: begin
                if (!tx_en)      state_nx = S_OFF;
                else if (wr_ok)  state_nx = S_SEND;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '1;
            cnt       <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (!tx_en) begin
            hold_full <= 1'b0;
        end else if (state == S_OFF) begin
            sh  <= '1;
            cnt <= flen;
        end else if (ld_direct) begin
            sh  <= frame_of(wdata, word9, bit9_val);
            cnt <= flen;
        end else if (ld_hold) begin
            sh        <= frame_of(next_word, word9, bit9_val);
            cnt       <= flen;
            hold_full <= 1'b0;
        end else begin
            if (busy && tick) begin
                sh  <= {1'b1, sh[FW-1:1]};
                cnt <= cnt - CW'(1);
            end
            if (wr_busy) begin
                hold      <= wdata;
                hold_full <= 1'b1;
            end
        end
    end

    always_comb begin
        txd = busy ? sh[0] : 1'b1;
    end

    // R4
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_direct || ld_hold) |=> !txd);
    // R2
    off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);
    // R3
    enable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF && tx_en) |=> (state == S_IDLE_FRAME && txd));
    // R4
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt != '0));
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_status,
    input  logic wr_ok,
    input  logic ld_direct,
    input  logic ld_hold,
    input  logic done_empty,
    input  logic be_ie,
    input  logic tc_ie,
    output logic be_o,
    output logic tc_o,
    output logic irq
);
    logic armed, set_be, set_tc, clr;

    always_comb begin
        set_be = ld_direct || ld_hold;
        set_tc = done_empty;
        clr    = armed && wr_ok;
        irq    = (be_o && be_ie) || (tc_o && tc_ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_o  <= 1'b1;
            tc_o  <= 1'b1;
            armed <= 1'b0;
        end else begin
            if (set_be)   be_o <= 1'b1;
            else if (clr) be_o <= 1'b0;
            if (set_tc)   tc_o <= 1'b1;
            else if (clr) tc_o <= 1'b0;
            if (set_be || set_tc || clr) armed <= 1'b0;
            else if (rd_status)          armed <= 1'b1;
        end
    end

    // R9
    no_clear_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !armed && tc_o) |=> tc_o);
    // R10
    disarm_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_be || set_tc) |=> !armed);
    // R8
    tc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tc_o) |-> $past(set_tc));
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          tx_en,
    input  logic          word9,
    input  logic          bit9_val,
    input  logic          be_ie,
    input  logic          tc_ie,
    input  logic          rd_status,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    output logic          txd,
    output logic          buf_empty,
    output logic          xfer_done,
    output logic          irq
);
    logic ld_direct, ld_hold, done_empty, wr_ok;

    sertx_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_en(tx_en),
        .word9(word9), .bit9_val(bit9_val), .wr(wr_data), .wdata(wdata),
        .txd(txd), .ld_direct(ld_direct), .ld_hold(ld_hold),
        .done_empty(done_empty), .wr_ok(wr_ok)
    );

    sertx_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rd_status(rd_status), .wr_ok(wr_ok),
        .ld_direct(ld_direct), .ld_hold(ld_hold), .done_empty(done_empty),
        .be_ie(be_ie), .tc_ie(tc_ie), .be_o(buf_empty), .tc_o(xfer_done),
        .irq(irq)
    );

    // R6
    direct_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_direct |=> buf_empty);
endmodule

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0, baud_tick = 0, tx_en = 0, word9 = 0, bit9_val = 0;
    logic be_ie = 0, tc_ie = 0, rd_status = 0, wr_data = 0;
    logic [7:0] wdata = '0;
    logic txd, buf_empty, xfer_done, irq;
    int checks = 0, errors = 0;

    // {word9, bit9_val, data}
    localparam logic [9:0] VEC [4] = '{10'h0A5, 10'h33C, 10'h281, 10'h0FF};

    always #(CLK_P/2) clk = ~clk;

    sertx_top u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .word9(word9), .bit9_val(bit9_val), .be_ie(be_ie), .tc_ie(tc_ie),
        .rd_status(rd_status), .wr_data(wr_data), .wdata(wdata),
        .txd(txd), .buf_empty(buf_empty), .xfer_done(xfer_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic m9, input logic b8,
                                              input logic [7:0] d);
        return m9 ? {1'b1, b8, d, 1'b0} : {2'b11, d, 1'b0};
    endfunction

    task automatic do_tick(output logic s);
        @(negedge clk); baud_tick = 1; s = txd;
        @(negedge clk); baud_tick = 0;
    endtask

    task automatic wr_word(input logic arm, input logic [7:0] d);
        @(negedge clk); rd_status = arm;
        @(negedge clk); rd_status = 0; wdata = d; wr_data = 1;
        @(negedge clk); wr_data = 0;
    endtask

    task automatic send_check(input string tag, input logic [10:0] f,
                              input int len, input int rd_at);
        logic s;
        for (int i = 0; i < len; i++) begin
            if (i == rd_at) begin
                @(negedge clk); rd_status = 1;
                @(negedge clk); rd_status = 0;
            end
            do_tick(s);
            chk($sformatf("%s bit%0d", tag, i), s, f[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 xfer_done", xfer_done, 1);
        chk("R1 txd", txd, 1);
        chk("R1 irq", irq, 0);

        // R2 disabled: writes ignored
        wr_word(1, 8'h5A);
        chk("R2 txd", txd, 1);
        chk("R2 buf_empty", buf_empty, 1);
        chk("R2 xfer_done", xfer_done, 1);
        for (int i = 0; i < 3; i++) begin
            do_tick(s);
            chk("R2 line idle", s, 1);
        end

        // R3 idle frame, word queued during it (R7)
        @(negedge clk); tx_en = 1;
        @(negedge clk);
        wr_word(1, 8'hC3);
        chk("R7 buf_empty queued", buf_empty, 0);
        send_check("R3 idle", 11'h7FF, 10, -1);
        chk("R7 buf_empty moved", buf_empty, 1);
        chk("R8 no done while pending", xfer_done, 0);
        send_check("R4 C3", exp_frame(0, 0, 8'hC3), 10, -1);
        chk("R8 done", xfer_done, 1);

        // vector table: R4 R5 R6 R8 R9
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); word9 = VEC[v][9]; bit9_val = VEC[v][8];
            wr_word(1, VEC[v][7:0]);
            chk($sformatf("R6 vec%0d buf_empty", v), buf_empty, 1);
            chk($sformatf("R9 vec%0d cleared", v), xfer_done, 0);
            send_check($sformatf("R5 vec%0d", v),
                       exp_frame(VEC[v][9], VEC[v][8], VEC[v][7:0]),
                       VEC[v][9] ? 11 : 10, -1);
            chk($sformatf("R8 vec%0d done", v), xfer_done, 1);
        end

        // R7 back to back, R11 interrupts
        @(negedge clk); word9 = 0; be_ie = 1;
        wr_word(1, 8'h12);
        wr_word(1, 8'h34);
        chk("R7 buf_empty held", buf_empty, 0);
        chk("R11 irq low", irq, 0);
        send_check("R7 first", exp_frame(0, 0, 8'h12), 10, -1);
        chk("R7 moved", buf_empty, 1);
        chk("R8 pending no done", xfer_done, 0);
        chk("R11 irq be", irq, 1);
        send_check("R7 second", exp_frame(0, 0, 8'h34), 10, -1);
        chk("R8 done b2b", xfer_done, 1);

        // R9 write without status read
        wr_word(0, 8'h77);
        chk("R9 unarmed keeps done", xfer_done, 1);
        send_check("R9 frame", exp_frame(0, 0, 8'h77), 10, -1);

        // R10 read then flag event disarms
        wr_word(1, 8'h0F);
        chk("R10 cleared", xfer_done, 0);
        send_check("R10 frame", exp_frame(0, 0, 8'h0F), 10, 3);
        chk("R10 done", xfer_done, 1);
        wr_word(0, 8'hF0);
        chk("R10 disarmed keeps done", xfer_done, 1);
        send_check("R10 frame2", exp_frame(0, 0, 8'hF0), 10, -1);

        // R11 transfer-complete source alone
        @(negedge clk); be_ie = 0; tc_ie = 1;
        @(negedge clk);
        chk("R11 irq tc", irq, 1);
        @(negedge clk); tc_ie = 0;
        @(negedge clk);
        chk("R11 irq off", irq, 0);

        // R2 disable mid frame
        wr_word(1, 8'h00);
        do_tick(s);
        chk("R2 start seen", s, 0);
        @(negedge clk); tx_en = 0;
        @(negedge clk);
        chk("R2 disable high", txd, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule